// File: doc/BRIEF.md
# Per-bit masked control register bank

This block holds a small set of 16-bit control registers behind a plain 32-bit write/read bus. Each write word has two halves. The upper half is a per-bit enable for the lower half, so software can set or clear any group of control bits in one bus write, with no read-modify-write and no risk of losing a bit that another agent changed. Only the register selected by the address is affected, and only in the bits whose enable is set.

Two registers can be written. The lane control register sits at offset 0xE214. Four of its bits, starting at position 3, turn off idle for each of four lanes. The configuration-port control register sits at offset 0xE220. A third offset, 0xE2A4, is a read-only window onto a 16-bit status input from outside the block. A read is accepted in one cycle and the word is returned on the next cycle, flagged by a valid pulse.

Top module: `hwm_reg_bank`

## Requirements
- R1: After a synchronous active-high reset, both writable registers hold zero, `lane_idle_off_o` is 0 and `rd_valid` is low.
- R2: On a write, lower data bit n is stored only when bit n+16 of the write word is set. Every stored bit whose enable bit is clear keeps its old value.
- R3: A write whose enable half `wr_data[31:16]` is all zero leaves the addressed register unchanged.
- R4: A read strobe sampled at a clock edge gives `rd_valid` high with `rd_data` on that edge. The upper 16 bits of `rd_data` are zero. When `rd_valid` is low, `rd_data` is zero.
- R5: The lane control register is at offset 0xE214. Lane k (k = 0..3) has its idle-off output `lane_idle_off_o[k]` equal to bit k+3 of that register. All 16 bits are on `lane_ctl_o`.
- R6: The configuration-port control register is at offset 0xE220, reads back at that offset, and drives `cfg_ctl_o`.
- R7: A read at offset 0xE2A4 returns `stat_in` as it was at the read strobe. A write to 0xE2A4 changes no register.
- R8: A write to any other offset changes no register. A read from any other offset returns zero.
- R9: A register changes only at the clock edge where `wr_stb` is sampled high. It keeps its old value before that edge and while `wr_stb` is low, whatever is on the address and data pins.
- R10: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe |
| wr_addr | input | 16 | Write byte offset |
| wr_data | input | 32 | Write word: [31:16] bit enables, [15:0] values |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | 16 | Read byte offset |
| rd_data | output | 32 | Read word, [31:16] zero |
| rd_valid | output | 1 | Read word valid, one cycle after the strobe |
| stat_in | input | 16 | External status shown at the status offset |
| lane_ctl_o | output | 16 | Lane control register contents |
| lane_idle_off_o | output | 4 | Per-lane idle-off controls |
| cfg_ctl_o | output | 16 | Configuration-port control register contents |

## Verification
The hardest case is showing that bits without an enable truly hold their value. A write that rewrites a bit to the value it already has proves nothing. So the stimulus first loads the configuration register with a mixed pattern. It then writes values that are the complement of that pattern under partial enables, so any enable leak flips a visible bit. A walking single-bit enable covers every position. A strobe-low cycle with a full-enable word sitting on the pins, and a check of the output just before the strobe edge, pin down the exact cycle of each update.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
    localparam int HALF_W   = 16;
    localparam int DATA_W   = 2 * HALF_W;
    localparam int NUM_RW   = 2;
    localparam int NUM_REGS = 3;
    localparam int RW_LANE  = 0;
    localparam int RW_CFG   = 1;
    localparam int SEL_STAT = 2;

    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        half_t [NUM_RW-1:0] rw;
        logic [DATA_W-1:0]  rdata;
        logic               rvalid;
    } bank_t;
endpackage

// File: rtl/hwm_addr_dec.sv
module hwm_addr_dec
    import hwm_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] LANE_OFS = 16'hE214,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 16'hE220,
    parameter logic [ADDR_W-1:0] STAT_OFS = 16'hE2A4
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel
);
    localparam logic [ADDR_W-1:0] OFS [NUM_REGS] = '{LANE_OFS, CFG_OFS, STAT_OFS};

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign sel[g] = (addr == OFS[g]);
    end
endmodule

// File: rtl/hwm_mask_merge.sv
module hwm_mask_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] bit_en,
    output logic [W-1:0] result
);
    always_comb begin
        result = (old_val & ~bit_en) | (new_val & bit_en);
    end
endmodule

// File: rtl/hwm_rd_mux.sv
module hwm_rd_mux
    import hwm_pkg::*;
(
    input  logic [NUM_REGS-1:0]        sel,
    input  half_t [NUM_REGS-1:0]       vals,
    output logic [DATA_W-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                rdata[HALF_W-1:0] = rdata[HALF_W-1:0] | vals[i];
            end
        end
    end
endmodule

// File: rtl/hwm_reg_bank.sv
module hwm_reg_bank
    import hwm_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] LANE_OFS  = 16'hE214,
    parameter logic [ADDR_W-1:0] CFG_OFS   = 16'hE220,
    parameter logic [ADDR_W-1:0] STAT_OFS  = 16'hE2A4,
    parameter int                LANES     = 4,
    parameter int                IDLE_BASE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    input  logic [15:0]       stat_in,
    output logic [15:0]       lane_ctl_o,
    output logic [LANES-1:0]  lane_idle_off_o,
    output logic [15:0]       cfg_ctl_o
);
    bank_t                st_q, st_d;
    logic [NUM_REGS-1:0]  wsel, rsel;
    half_t [NUM_REGS-1:0] rd_vals;
    half_t                merged [NUM_RW];
    logic [DATA_W-1:0]    rd_word;

    hwm_addr_dec #(.ADDR_W(ADDR_W), .LANE_OFS(LANE_OFS), .CFG_OFS(CFG_OFS), .STAT_OFS(STAT_OFS))
        u_wdec (.addr(wr_addr), .sel(wsel));

    hwm_addr_dec #(.ADDR_W(ADDR_W), .LANE_OFS(LANE_OFS), .CFG_OFS(CFG_OFS), .STAT_OFS(STAT_OFS))
        u_rdec (.addr(rd_addr), .sel(rsel));

    // One masked merge per writable register
    for (genvar g = 0; g < NUM_RW; g++) begin : g_merge
        hwm_mask_merge #(.W(HALF_W)) u_mm (
            .old_val (st_q.rw[g]),
            .new_val (wr_data[HALF_W-1:0]),
            .bit_en  (wr_data[DATA_W-1:HALF_W]),
            .result  (merged[g])
        );
    end

    assign rd_vals[RW_LANE]  = st_q.rw[RW_LANE];
    assign rd_vals[RW_CFG]   = st_q.rw[RW_CFG];
    assign rd_vals[SEL_STAT] = stat_in;

    hwm_rd_mux u_rmux (.sel(rsel), .vals(rd_vals), .rdata(rd_word));

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_RW; i++) begin
            if (wr_stb && wsel[i]) begin
                st_d.rw[i] = merged[i];
            end
        end
        st_d.rvalid = rd_stb;
        st_d.rdata  = rd_stb ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.rdata;
    assign rd_valid   = st_q.rvalid;
    assign lane_ctl_o = st_q.rw[RW_LANE];
    assign cfg_ctl_o  = st_q.rw[RW_CFG];

    for (genvar k = 0; k < LANES; k++) begin : g_idle
        assign lane_idle_off_o[k] = st_q.rw[RW_LANE][IDLE_BASE+k];
    end

    // R9: no strobe, no change
    a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(st_q.rw));

    // R3: all-zero enable half changes nothing
    a_r3_zero_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_data[DATA_W-1:HALF_W] == '0) |=> $stable(st_q.rw));

    // R2: only enabled bits of the config register may move
    a_r2_only_enabled_bits: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (((st_q.rw[RW_CFG] ^ $past(st_q.rw[RW_CFG]))
                     & ~$past(wr_data[DATA_W-1:HALF_W])) == '0));

    // R8: unmapped or read-only offsets change nothing
    a_r8_unmapped_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr != LANE_OFS && wr_addr != CFG_OFS) |=> $stable(st_q.rw));

    // R4: read latency and idle bus
    a_r4_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_valid);
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> (!rd_valid && rd_data == '0));
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/tb_hwm_reg_bank.sv
module tb_hwm_reg_bank;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_LANE = 16'hE214;
    localparam logic [15:0] A_CFG  = 16'hE220;
    localparam logic [15:0] A_STAT = 16'hE2A4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [15:0] stat_in = '0;
    logic [15:0] lane_ctl_o;
    logic [3:0]  lane_idle_off_o;
    logic [15:0] cfg_ctl_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_lane = '0;
    logic [15:0] m_cfg  = '0;
    logic [31:0] exp_q [$];
    string       req_q [$];

    hwm_reg_bank dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .stat_in(stat_in), .lane_ctl_o(lane_ctl_o), .lane_idle_off_o(lane_idle_off_o),
        .cfg_ctl_o(cfg_ctl_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] o, input logic [31:0] w);
        return (o & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        if (a == A_LANE) m_lane = merge(m_lane, d);
        if (a == A_CFG)  m_cfg  = merge(m_cfg, d);
    endtask

    task automatic do_read(input logic [15:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        rd_stb = 1'b1; rd_addr = a;
        if (a == A_LANE)      e = {16'h0, m_lane};
        else if (a == A_CFG)  e = {16'h0, m_cfg};
        else if (a == A_STAT) e = {16'h0, stat_in};
        else                  e = '0;
        exp_q.push_back(e);
        req_q.push_back(req);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic chk_outs(input string req);
        chk({req, " lane_ctl_o"}, {16'h0, lane_ctl_o}, {16'h0, m_lane});
        chk({req, " cfg_ctl_o"}, {16'h0, cfg_ctl_o}, {16'h0, m_cfg});
        chk({req, " lane_idle_off_o"}, {28'h0, lane_idle_off_o}, {28'h0, m_lane[6:3]});
    endtask

    // Monitor: compares each returned read against the scoreboard queue (R4)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected rd_valid", 32'h1, 32'h0);
                end else begin
                    chk(req_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_outs("R1");
        chk("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        do_read(A_LANE, "R1 lane read");
        do_read(A_CFG, "R1 cfg read");

        // R2 / R6: masked writes on the config register
        do_write(A_CFG, 32'hFFFF_A5C3);
        chk_outs("R6 full write");
        do_write(A_CFG, {16'h00F0, 16'h0000});
        chk_outs("R2 clear nibble");
        do_write(A_CFG, {16'h0F00, 16'h5AFF});
        chk_outs("R2 set nibble");
        do_write(A_CFG, {16'h3C3C, ~m_cfg});
        chk_outs("R2 complement under partial enable");
        do_read(A_CFG, "R6 cfg read");

        // R3 zero enable
        do_write(A_CFG, {16'h0000, 16'hFFFF});
        chk_outs("R3 zero mask");
        do_read(A_CFG, "R3 cfg read");

        // R2 walking single-bit enables
        for (int b = 0; b < 16; b++) begin
            do_write(A_CFG, {16'h0001 << b, ~m_cfg});
            chk_outs("R2 walk");
        end
        do_read(A_CFG, "R2 walk read");

        // R5 lanes and R10 isolation
        do_write(A_LANE, {16'h0078, 16'h0028});
        chk_outs("R5 lanes 0,2");
        chk("R5 idle bits", {28'h0, lane_idle_off_o}, 32'h5);
        do_write(A_LANE, {16'h0008, 16'h0000});
        chk("R5 lane 0 cleared", {28'h0, lane_idle_off_o}, 32'h4);
        chk_outs("R10 lane write keeps cfg");
        do_read(A_LANE, "R5 lane read");

        // R7 status window
        stat_in = 16'h1234;
        do_read(A_STAT, "R7 status read");
        do_write(A_STAT, 32'hFFFF_FFFF);
        chk_outs("R7 status write ignored");
        stat_in = 16'hBEEF;
        do_read(A_STAT, "R7 status follows input");

        // R8 unmapped
        do_write(16'hE218, 32'hFFFF_0000);
        chk_outs("R8 unmapped write");
        do_read(16'hE218, "R8 unmapped read");
        do_read(16'h0214, "R8 alias read");

        // R9 strobe-low with full word on pins, then timing of the update edge
        @(negedge clk);
        wr_addr = A_CFG; wr_data = {16'hFFFF, ~m_cfg};
        @(negedge clk);
        chk_outs("R9 no strobe");
        wr_stb = 1'b1;
        #1;
        chk("R9 before edge", {16'h0, cfg_ctl_o}, {16'h0, m_cfg});
        @(negedge clk);
        wr_stb = 1'b0;
        m_cfg = merge(m_cfg, wr_data);
        chk_outs("R9 after edge");
        do_read(A_CFG, "R9 cfg read");

        repeat (3) @(negedge clk);
        chk("R4 all reads returned", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule